// File: doc/BRIEF.md
# Block Protection Register Bank

This block holds one protection register for each of the uniform blocks of a flash-style memory. There are eight blocks of 64 KB each by default. Each register carries three live bits: a write-lock, a lock-down and a read-lock. The remaining bits of the register byte are fixed. The bus interface reaches the registers through a plain register port. A write is presented as a one-cycle strobe with an index and a byte. A read is a combinational lookup by index.

Every array access that the bus interface is about to perform is also offered to the block, as a kind (read, program or erase), an address and the array data. One cycle later the block returns a verdict and the data to send back. Program and erase are refused when either of two things holds. The first is that the target register is write-locked. The second is that one of the two active-low protect pins covers the block. The top-block pin guards only the highest block. The write-protect pin guards a parameterised set of blocks, which by default is every block except the top one. A refusal raises a protection-error flag that the status logic records as its own failure cause. A read of a read-locked block is not given array data; it returns a fixed fill byte instead.

The result stream has no back-pressure. Every accepted access produces exactly one result cycle, and the consumer must take it in that cycle. There is no ready signal on either side.

Top module: `lockreg_bank`

## Requirements
- R1: After reset, every protection register reads 8'h01: write-locked, with lock-down and read-lock clear.
- R2: `reg_rdata` shows the register chosen by `reg_ridx` in the same cycle. The write-lock is at bit 0, the lock-down at bit 1 and the read-lock at bit 2.
- R3: A write with `reg_we` high changes the register chosen by `reg_widx`, and the new value reads back from the next cycle on. Bits 7 to 3 always read 0 and ignore the written data.
- R4: Once a register's lock-down bit is 1, writes no longer change its bits 0 and 1 until the next reset. Bit 2 stays writable.
- R5: Each cycle with `acc_valid` high produces `res_valid` high exactly one cycle later. When no access was presented, `res_valid` is low.
- R6: A program or erase to a block whose write-lock is 1 gives `res_permit` = 0 and `res_prot_err` = 1. A program or erase to an unprotected block gives `res_permit` = 1 and `res_prot_err` = 0.
- R7: While `tbl_n` is low, program and erase to the top block (block 7) are refused with `res_prot_err` = 1, whatever the register holds. Other blocks are not affected by this pin.
- R8: While `wp_n` is low, program and erase to blocks in `WP_MASK` (blocks 0 to 6 by default) are refused with `res_prot_err` = 1. The top block is not affected by this pin.
- R9: A read of a read-locked block gives `res_permit` = 0 and `res_data` = 8'hFF. Any other read gives `res_permit` = 1 and `res_data` equal to the `acc_data` presented with it.
- R10: The access kind is encoded as 2'b00 read, 2'b01 program, and 2'b10 or 2'b11 erase. A read never raises `res_prot_err`, and the pins do not affect reads.
- R11: The block number is address bits 18 to 16, so block n spans n*64K to n*64K+65535.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tbl_n | input | 1 | Top-block protect pin, active low |
| wp_n | input | 1 | Write-protect pin, active low |
| reg_we | input | 1 | Register write strobe |
| reg_widx | input | 3 | Register index for the write |
| reg_wdata | input | 8 | Register write byte |
| reg_ridx | input | 3 | Register index for the read |
| reg_rdata | output | 8 | Register read byte |
| acc_valid | input | 1 | Access presented this cycle |
| acc_kind | input | 2 | Access kind: read, program or erase |
| acc_addr | input | 19 | Access byte address |
| acc_data | input | 8 | Array data for a read |
| res_valid | output | 1 | Verdict valid |
| res_permit | output | 1 | Access allowed |
| res_prot_err | output | 1 | Program or erase refused by protection |
| res_data | output | 8 | Data returned for a read |

## Verification
The register read path has no latency. The bench changes `reg_ridx`, waits a fraction of a cycle and then compares `reg_rdata`. A register write lands on the clock edge that ends its strobe cycle, so the read-back is taken after the next falling edge. An access verdict leaves a single register stage. The bench therefore drives an access at one falling edge and samples the four result outputs at the following falling edge, one rising edge later. It samples once more one cycle after the access is dropped, to confirm that `res_valid` has returned low.

// File: rtl/lockreg_pkg.sv
package lockreg_pkg;
  // Live bits of one protection register, packed so that wl is bit 0.
  typedef struct packed {
    logic rl;  // read-lock
    logic ld;  // lock-down
    logic wl;  // write-lock
  } lock_t;

  localparam int LOCK_BITS = 3;

  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_PROG  = 2'b01,
    ACC_ERASE = 2'b10,
    ACC_ERAS2 = 2'b11
  } acc_kind_e;

  localparam lock_t LOCK_RST = '{rl: 1'b0, ld: 1'b0, wl: 1'b1};
endpackage

// File: rtl/lockreg_cell.sv
module lockreg_cell
  import lockreg_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [LOCK_BITS-1:0] wbits,
  output lock_t                q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= LOCK_RST;
    end else if (we) begin
      q.rl <= wbits[2];
      // lock-down freezes itself and the write-lock until reset
      if (!q.ld) begin
        q.ld <= wbits[1];
        q.wl <= wbits[0];
      end
    end
  end
endmodule

// File: rtl/lockreg_gate.sv
module lockreg_gate
  import lockreg_pkg::*;
#(
  parameter int                 NUM_BLK = 8,
  parameter int                 BLK_AW  = 16,
  parameter int                 DW      = 8,
  parameter logic [DW-1:0]      FILL    = 8'hFF,
  parameter logic [NUM_BLK-1:0] WP_MASK = {1'b0, {(NUM_BLK-1){1'b1}}},
  localparam int                BIDX_W  = $clog2(NUM_BLK),
  localparam int                AW      = BLK_AW + BIDX_W
)(
  input  logic                  clk,
  input  logic                  rst_n,
  input  lock_t [NUM_BLK-1:0]   locks,
  input  logic                  tbl_n,
  input  logic                  wp_n,
  input  logic                  acc_valid,
  input  logic [1:0]            acc_kind,
  input  logic [AW-1:0]         acc_addr,
  input  logic [DW-1:0]         acc_data,
  output logic                  res_valid,
  output logic                  res_permit,
  output logic                  res_prot_err,
  output logic [DW-1:0]         res_data
);
  localparam logic [BIDX_W-1:0] TOP_BLK = BIDX_W'(NUM_BLK - 1);

  logic [BIDX_W-1:0] blk;
  lock_t             sel;
  logic              is_rd, pin_top, pin_wp, deny_wr, unused_lo;

  assign blk       = acc_addr[AW-1:BLK_AW];
  assign unused_lo = ^acc_addr[BLK_AW-1:0];
  assign sel       = locks[blk];
  assign is_rd     = (acc_kind == ACC_READ);
  assign pin_top   = (blk == TOP_BLK) && !tbl_n;
  assign pin_wp    = WP_MASK[blk] && !wp_n;
  assign deny_wr   = sel.wl || pin_top || pin_wp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid    <= 1'b0;
      res_permit   <= 1'b0;
      res_prot_err <= 1'b0;
      res_data     <= '0;
    end else begin
      res_valid <= acc_valid;
      if (acc_valid) begin
        if (is_rd) begin
          res_permit   <= !sel.rl;
          res_prot_err <= 1'b0;
          res_data     <= sel.rl ? FILL : acc_data;
        end else begin
          res_permit   <= !deny_wr;
          res_prot_err <= deny_wr;
          res_data     <= '0;
        end
      end else begin
        res_permit   <= 1'b0;
        res_prot_err <= 1'b0;
        res_data     <= '0;
      end
    end
  end
endmodule

// File: rtl/lockreg_bank.sv
module lockreg_bank
  import lockreg_pkg::*;
#(
  parameter int                 NUM_BLK = 8,
  parameter int                 BLK_AW  = 16,
  parameter int                 DW      = 8,
  parameter logic [DW-1:0]      FILL    = 8'hFF,
  parameter logic [NUM_BLK-1:0] WP_MASK = {1'b0, {(NUM_BLK-1){1'b1}}},
  localparam int                BIDX_W  = $clog2(NUM_BLK),
  localparam int                AW      = BLK_AW + BIDX_W
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tbl_n,
  input  logic              wp_n,
  input  logic              reg_we,
  input  logic [BIDX_W-1:0] reg_widx,
  input  logic [DW-1:0]     reg_wdata,
  input  logic [BIDX_W-1:0] reg_ridx,
  output logic [DW-1:0]     reg_rdata,
  input  logic              acc_valid,
  input  logic [1:0]        acc_kind,
  input  logic [AW-1:0]     acc_addr,
  input  logic [DW-1:0]     acc_data,
  output logic              res_valid,
  output logic              res_permit,
  output logic              res_prot_err,
  output logic [DW-1:0]     res_data
);
  lock_t [NUM_BLK-1:0] locks;
  logic                unused_hi;

  // reserved upper write bits are dropped
  assign unused_hi = ^reg_wdata[DW-1:LOCK_BITS];

  for (genvar i = 0; i < NUM_BLK; i++) begin : g_cell
    lockreg_cell u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (reg_we && (reg_widx == BIDX_W'(i))),
      .wbits (reg_wdata[LOCK_BITS-1:0]),
      .q     (locks[i])
    );
  end

  assign reg_rdata = {{(DW-LOCK_BITS){1'b0}}, locks[reg_ridx]};

  lockreg_gate #(
    .NUM_BLK (NUM_BLK),
    .BLK_AW  (BLK_AW),
    .DW      (DW),
    .FILL    (FILL),
    .WP_MASK (WP_MASK)
  ) u_gate (
    .clk          (clk),
    .rst_n        (rst_n),
    .locks        (locks),
    .tbl_n        (tbl_n),
    .wp_n         (wp_n),
    .acc_valid    (acc_valid),
    .acc_kind     (acc_kind),
    .acc_addr     (acc_addr),
    .acc_data     (acc_data),
    .res_valid    (res_valid),
    .res_permit   (res_permit),
    .res_prot_err (res_prot_err),
    .res_data     (res_data)
  );
endmodule

// File: rtl/lockreg_bank_sva.sv
module lockreg_bank_sva
  import lockreg_pkg::*;
#(
  parameter int                 NUM_BLK = 8,
  parameter int                 BLK_AW  = 16,
  parameter int                 DW      = 8,
  parameter logic [DW-1:0]      FILL    = 8'hFF,
  parameter logic [NUM_BLK-1:0] WP_MASK = {1'b0, {(NUM_BLK-1){1'b1}}},
  localparam int                BIDX_W  = $clog2(NUM_BLK),
  localparam int                AW      = BLK_AW + BIDX_W
)(
  input logic                clk,
  input logic                rst_n,
  input logic                tbl_n,
  input logic                wp_n,
  input lock_t [NUM_BLK-1:0] locks,
  input logic [DW-1:0]       reg_rdata,
  input logic                acc_valid,
  input logic [1:0]          acc_kind,
  input logic [AW-1:0]       acc_addr,
  input logic                res_valid,
  input logic                res_permit,
  input logic                res_prot_err,
  input logic [DW-1:0]       res_data
);
  localparam logic [BIDX_W-1:0] TOP_BLK = BIDX_W'(NUM_BLK - 1);
  logic [BIDX_W-1:0] blk;
  assign blk = acc_addr[AW-1:BLK_AW];

  for (genvar i = 0; i < NUM_BLK; i++) begin : g_ld
    AST_LD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      locks[i].ld |=> locks[i].ld); // R4
    AST_LD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      locks[i].ld |=> $stable(locks[i].wl)); // R4
  end

  AST_RESV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[DW-1:LOCK_BITS] == '0); // R3
  AST_RES_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> res_valid); // R5
  AST_RES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !res_valid); // R5
  AST_WLOCK_DENY: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && acc_kind != 2'b00 && locks[blk].wl |=> !res_permit && res_prot_err); // R6
  AST_TOP_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && acc_kind != 2'b00 && blk == TOP_BLK && !tbl_n
      |=> !res_permit && res_prot_err); // R7
  AST_WP_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && acc_kind != 2'b00 && WP_MASK[blk] && !wp_n
      |=> !res_permit && res_prot_err); // R8
  AST_RLOCK_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && acc_kind == 2'b00 && locks[blk].rl
      |=> !res_permit && res_data == FILL); // R9
  AST_READ_NOERR: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && acc_kind == 2'b00 |=> !res_prot_err); // R10
endmodule

bind lockreg_bank lockreg_bank_sva #(
  .NUM_BLK (NUM_BLK),
  .BLK_AW  (BLK_AW),
  .DW      (DW),
  .FILL    (FILL),
  .WP_MASK (WP_MASK)
) u_sva (
  .clk          (clk),
  .rst_n        (rst_n),
  .tbl_n        (tbl_n),
  .wp_n         (wp_n),
  .locks        (locks),
  .reg_rdata    (reg_rdata),
  .acc_valid    (acc_valid),
  .acc_kind     (acc_kind),
  .acc_addr     (acc_addr),
  .res_valid    (res_valid),
  .res_permit   (res_permit),
  .res_prot_err (res_prot_err),
  .res_data     (res_data)
);

// File: tb/lockreg_bank_tb_top.sv
`timescale 1ns/1ps
module lockreg_bank_tb_top;
  logic       clk = 1'b0;
  logic       rst_n, tbl_n, wp_n, reg_we, acc_valid;
  logic [2:0] reg_widx, reg_ridx;
  logic [7:0] reg_wdata, reg_rdata, acc_data, res_data;
  logic [1:0] acc_kind;
  logic [18:0] acc_addr;
  logic       res_valid, res_permit, res_prot_err;
  int         n_chk = 0, n_bad = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  lockreg_bank dut_i (
    .clk(clk), .rst_n(rst_n), .tbl_n(tbl_n), .wp_n(wp_n),
    .reg_we(reg_we), .reg_widx(reg_widx), .reg_wdata(reg_wdata),
    .reg_ridx(reg_ridx), .reg_rdata(reg_rdata),
    .acc_valid(acc_valid), .acc_kind(acc_kind), .acc_addr(acc_addr),
    .acc_data(acc_data), .res_valid(res_valid), .res_permit(res_permit),
    .res_prot_err(res_prot_err), .res_data(res_data)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic reg_wr(input logic [2:0] idx, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_widx = idx; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_chk(string req, input logic [2:0] idx, input logic [7:0] exp);
    reg_ridx = idx;
    #1;
    check(req, reg_rdata, exp);
  endtask

  // Drive at a falling edge, sample one rising edge later, then drop.
  task automatic access(string req, input logic [1:0] kind, input logic [18:0] addr,
                        input logic [7:0] d, input logic permit, input logic err,
                        input logic [7:0] rdat);
    @(negedge clk);
    acc_valid = 1'b1; acc_kind = kind; acc_addr = addr; acc_data = d;
    @(negedge clk);
    acc_valid = 1'b0;
    check({req, " valid"}, res_valid, 1);
    check({req, " permit"}, res_permit, permit);
    check({req, " err"}, res_prot_err, err);
    if (kind == 2'b00) check({req, " data"}, res_data, rdat);
  endtask

  task automatic t_reset_defaults();
    for (int i = 0; i < 8; i++) reg_chk("R1 default", 3'(i), 8'h01);
    check("R5 idle after reset", res_valid, 0);
  endtask

  task automatic t_reg_write();
    reg_wr(3'd3, 8'hFC);
    reg_chk("R3 reserved ignored", 3'd3, 8'h04);
    reg_chk("R2 neighbour untouched", 3'd2, 8'h01);
    reg_wr(3'd3, 8'h00);
    reg_chk("R2 cleared", 3'd3, 8'h00);
  endtask

  task automatic t_write_lock();
    access("R6 unlocked program", 2'b01, 19'h3_1234, 8'h00, 1, 0, 8'h00);
    access("R6 locked program", 2'b01, 19'h2_0000, 8'h00, 0, 1, 8'h00);
    access("R10 kind 11 erase", 2'b11, 19'h2_FFFF, 8'h00, 0, 1, 8'h00);
    access("R11 block boundary", 2'b10, 19'h3_FFFF, 8'h00, 1, 0, 8'h00);
    access("R11 next block", 2'b10, 19'h4_0000, 8'h00, 0, 1, 8'h00);
  endtask

  task automatic t_read_lock();
    reg_wr(3'd5, 8'h04);
    access("R9 read-locked", 2'b00, 19'h5_0010, 8'h3C, 0, 0, 8'hFF);
    access("R9 plain read", 2'b00, 19'h3_0010, 8'h3C, 1, 0, 8'h3C);
    access("R10 read of write-locked", 2'b00, 19'h1_0000, 8'hA5, 1, 0, 8'hA5);
  endtask

  task automatic t_lockdown();
    reg_wr(3'd4, 8'h02);
    reg_chk("R4 set lock-down", 3'd4, 8'h02);
    reg_wr(3'd4, 8'h01);
    reg_chk("R4 wl frozen", 3'd4, 8'h02);
    reg_wr(3'd4, 8'h04);
    reg_chk("R4 rl writable", 3'd4, 8'h06);
    reg_wr(3'd4, 8'h00);
    reg_chk("R4 ld sticky", 3'd4, 8'h02);
    access("R4 frozen unlocked", 2'b01, 19'h4_0000, 8'h00, 1, 0, 8'h00);
  endtask

  task automatic t_top_pin();
    reg_wr(3'd7, 8'h00);
    tbl_n = 1'b0;
    access("R7 top program", 2'b01, 19'h7_FFFF, 8'h00, 0, 1, 8'h00);
    access("R7 top erase", 2'b10, 19'h7_0000, 8'h00, 0, 1, 8'h00);
    access("R10 top read with pin", 2'b00, 19'h7_0000, 8'h5A, 1, 0, 8'h5A);
    access("R7 other block free", 2'b01, 19'h3_0000, 8'h00, 1, 0, 8'h00);
    tbl_n = 1'b1;
    access("R7 pin released", 2'b01, 19'h7_0000, 8'h00, 1, 0, 8'h00);
  endtask

  task automatic t_wp_pin();
    wp_n = 1'b0;
    access("R8 covered block", 2'b10, 19'h3_0000, 8'h00, 0, 1, 8'h00);
    access("R8 top not covered", 2'b01, 19'h7_0000, 8'h00, 1, 0, 8'h00);
    access("R10 read with wp", 2'b00, 19'h3_0000, 8'h11, 1, 0, 8'h11);
    wp_n = 1'b1;
    access("R8 pin released", 2'b10, 19'h3_0000, 8'h00, 1, 0, 8'h00);
  endtask

  task automatic t_latency();
    @(negedge clk);
    check("R5 no access no result", res_valid, 0);
  endtask

  task automatic t_reset_again();
    do_reset();
    reg_chk("R1 re-reset lock-down clear", 3'd4, 8'h01);
    reg_chk("R1 re-reset read-lock clear", 3'd5, 8'h01);
    access("R1 default locks program", 2'b01, 19'h3_0000, 8'h00, 0, 1, 8'h00);
  endtask

  initial begin
    rst_n = 1'b0; tbl_n = 1'b1; wp_n = 1'b1; reg_we = 1'b0;
    reg_widx = '0; reg_wdata = '0; reg_ridx = '0;
    acc_valid = 1'b0; acc_kind = '0; acc_addr = '0; acc_data = '0;
    do_reset();
    t_reset_defaults();
    t_reg_write();
    t_write_lock();
    t_read_lock();
    t_lockdown();
    t_top_pin();
    t_wp_pin();
    t_latency();
    t_reset_again();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule